// File: doc/BRIEF.md
# Region-Indexed Switching Pattern Sequencer

This block drives the four switching-cell pairs of a five-level flying-capacitor converter. A parameterised divider turns the system clock into a sampling tick. Every eighth tick marks a pattern boundary. At that boundary the block reads the three most recently captured capacitor-voltage codes and clamps each one into its safety window. It compares each clamped value with the centre of its window, which places the voltage vector in one of eight sub-boxes. The block then selects the eight-mode switching pattern stored for that sub-box.

On each tick the sequencer applies the next mode of the chosen pattern to a 4-bit switch-state output. Each bit of that output sets the position of one complementary cell pair. A mode may change only one bit from the mode applied before it. A candidate that would change zero bits or several bits is refused: the present mode stays and a sticky fault flag is set. A second sticky flag records any boundary sample that lay outside the safety box. The pattern table is loaded at reset with a built-in legal set and can be overwritten one entry at a time through a write port.

Top module: `cap_region_sequencer`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and until the first tick after it, `mode_o` is 0000, `region_o` is 0, and `tick_o`, `out_of_range_o` and `illegal_transition_o` are 0.
- R2: `tick_o` is a one-clock pulse that repeats every `TICK_DIV` clocks. The first pulse comes `TICK_DIV` clocks after reset is released.
- R3: `mode_o` changes only on a clock edge at which `tick_o` is high.
- R4: On the first tick after reset and on every eighth tick after that, `region_o` becomes {v1>=V1_MID, v2>=V2_MID, v3>=V3_MID}, with v1 in bit 2 and v3 in bit 0. `region_o` holds its value over the other seven ticks of the pattern.
- R5: The tick that selects a region applies step 0 of that region's pattern. The next seven ticks apply steps 1 to 7 in order.
- R6: After reset, step k of region r holds the default mode. Take the base b(k) = 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000 for k = 0..7. Rotate b(k) left by r[1:0] bit places. If r[2] is 1, reverse the bit order of the result.
- R7: At a pattern boundary, any sampled voltage below its LO bound or above its HI bound sets `out_of_range_o`. The flag stays set until reset. The voltage is clamped into its window before classification.
- R8: A candidate mode that differs from the applied mode in a number of bits other than one is not applied. `mode_o` holds its value, and `illegal_transition_o` is set and stays set until reset.
- R9: A clock edge with `rom_wr_en` high stores `rom_wr_mode` at (`rom_wr_region`, `rom_wr_step`). Later uses of that entry return the new mode.
- R10: Any two successive values of `mode_o` differ in exactly one bit.
- R11: The voltage codes are captured only on edges where `sample_valid` is high. Classification uses the latest captured codes, which are reset to the three MID values. A sample captured in the middle of a pattern does not change the running pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| v1_code | input | SMP_W | Outer capacitor voltage code (1 code per volt with defaults) |
| v2_code | input | SMP_W | Middle capacitor voltage code |
| v3_code | input | SMP_W | Inner capacitor voltage code |
| sample_valid | input | 1 | Capture strobe for the three voltage codes |
| rom_wr_en | input | 1 | Pattern table write enable |
| rom_wr_region | input | 3 | Region index of the entry written |
| rom_wr_step | input | 3 | Step index of the entry written |
| rom_wr_mode | input | 4 | Mode value written |
| mode_o | output | 4 | Applied switch-state vector, one bit per cell pair |
| region_o | output | 3 | Region selected for the running pattern |
| tick_o | output | 1 | Sampling tick pulse |
| out_of_range_o | output | 1 | Sticky flag: a boundary sample lay outside the box |
| illegal_transition_o | output | 1 | Sticky flag: a candidate mode was refused |

## Verification
The assertions assume that `TICK_DIV` is at least 2. Under that condition ticks cannot fall on adjacent edges, and a pattern boundary always has a captured sample ready. The assertions also assume that reset is held for at least one edge so that the default table is loaded. The stimulus meets these assumptions: it changes voltages and table entries only at falling clock edges, and it writes table entries only during the quiet gap after a pattern's last tick. That gap is wide because the bench uses a divider of 16, so the writes never fall on a region's step while that region is playing. The bench deliberately drives samples outside the box and writes table entries that break the one-bit rule, so that both sticky flags are exercised.

// File: rtl/crs_pkg.sv
package crs_pkg;

    localparam int CELLS   = 4;
    localparam int STEPS   = 8;
    localparam int REGIONS = 8;
    localparam int AXES    = 3;
    localparam int STEP_W  = $clog2(STEPS);
    localparam int REG_W   = $clog2(REGIONS);

    typedef logic [CELLS-1:0]  mode_t;
    typedef logic [STEP_W-1:0] step_t;
    typedef logic [REG_W-1:0]  region_t;

    typedef struct packed {
        region_t region;
        step_t   step;
    } rom_addr_t;

    typedef struct packed {
        step_t   step;
        region_t region;
        mode_t   mode;
        logic    oor;
        logic    ill;
    } seq_state_t;

    function automatic logic single_flip(mode_t a, mode_t b);
        return $countones(a ^ b) == 1;
    endfunction

    function automatic mode_t base_mode(step_t k);
        int kk;
        kk = int'(k);
        if (kk < CELLS)
            return mode_t'((1 << (kk + 1)) - 1);
        else
            return mode_t'(((1 << CELLS) - 1) << (kk - CELLS + 1));
    endfunction

    function automatic mode_t default_mode(region_t r, step_t k);
        logic [2*CELLS-1:0] wide;
        mode_t rot;
        mode_t res;
        wide = {base_mode(k), base_mode(k)} << r[1:0];
        rot  = wide[2*CELLS-1:CELLS];
        res  = rot;
        if (r[REG_W-1]) begin
            for (int i = 0; i < CELLS; i++) res[i] = rot[CELLS-1-i];
        end
        return res;
    endfunction

endpackage

// File: rtl/crs_tick_div.sv
module crs_tick_div #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (cnt == LAST) cnt <= '0;
        else                  cnt <= cnt + CW'(1);
    end

    assign tick = (cnt == LAST) && !rst;

    generate
        if (DIV > 1) begin : g_tick_chk
            // R2
            tick_isolated_chk: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/crs_region_classifier.sv
module crs_region_classifier #(
    parameter int VW     = 10,
    parameter int V1_LO  = 145, parameter int V1_MID = 150, parameter int V1_HI = 155,
    parameter int V2_LO  = 95,  parameter int V2_MID = 100, parameter int V2_HI = 105,
    parameter int V3_LO  = 45,  parameter int V3_MID = 50,  parameter int V3_HI = 55
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_valid,
    input  logic [VW-1:0]      v1,
    input  logic [VW-1:0]      v2,
    input  logic [VW-1:0]      v3,
    output crs_pkg::region_t   region,
    output logic               outside_any
);
    import crs_pkg::*;

    localparam logic [VW-1:0] LO_C  [AXES] = '{VW'(V1_LO),  VW'(V2_LO),  VW'(V3_LO)};
    localparam logic [VW-1:0] MID_C [AXES] = '{VW'(V1_MID), VW'(V2_MID), VW'(V3_MID)};
    localparam logic [VW-1:0] HI_C  [AXES] = '{VW'(V1_HI),  VW'(V2_HI),  VW'(V3_HI)};

    logic [VW-1:0]   smp [AXES];
    logic [AXES-1:0] outside;

    always_ff @(posedge clk) begin
        if (rst) begin
            smp[0] <= MID_C[0];
            smp[1] <= MID_C[1];
            smp[2] <= MID_C[2];
        end else if (sample_valid) begin
            smp[0] <= v1;
            smp[1] <= v2;
            smp[2] <= v3;
        end
    end

    generate
        for (genvar a = 0; a < AXES; a++) begin : g_axis
            logic          below;
            logic          above;
            logic [VW-1:0] clamped;
            assign below   = smp[a] < LO_C[a];
            assign above   = smp[a] > HI_C[a];
            assign clamped = below ? LO_C[a] : (above ? HI_C[a] : smp[a]);
            assign region[REG_W-1-a] = clamped >= MID_C[a];
            assign outside[a] = below | above;

            // R4
            axis_side_chk: assert property (@(posedge clk) disable iff (rst)
                (smp[a] >= MID_C[a]) |-> region[REG_W-1-a]);
            // R7
            axis_outside_chk: assert property (@(posedge clk) disable iff (rst)
                (smp[a] > HI_C[a] || smp[a] < LO_C[a]) |-> outside_any);
        end
    endgenerate

    assign outside_any = |outside;
endmodule

// File: rtl/crs_pattern_rom.sv
module crs_pattern_rom (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  crs_pkg::rom_addr_t  wr_addr,
    input  crs_pkg::mode_t      wr_mode,
    input  crs_pkg::rom_addr_t  rd_addr,
    output crs_pkg::mode_t      rd_mode
);
    import crs_pkg::*;

    localparam int DEPTH = REGIONS * STEPS;

    mode_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= default_mode(region_t'(i >> STEP_W), step_t'(i));
        end else if (wr_en) begin
            mem[wr_addr] <= wr_mode;
        end
    end

    assign rd_mode = mem[rd_addr];

    logic      chk_vld;
    rom_addr_t chk_addr;
    mode_t     chk_mode;
    always_ff @(posedge clk) begin
        chk_vld  <= !rst && wr_en;
        chk_addr <= wr_addr;
        chk_mode <= wr_mode;
    end

    // R9
    rom_write_chk: assert property (@(posedge clk) disable iff (rst)
        chk_vld |-> (mem[chk_addr] == chk_mode));
endmodule

// File: rtl/crs_mode_stepper.sv
module crs_mode_stepper (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  crs_pkg::region_t    new_region,
    input  logic                new_oor,
    input  crs_pkg::mode_t      rom_mode,
    output crs_pkg::rom_addr_t  rd_addr,
    output crs_pkg::mode_t      mode,
    output crs_pkg::region_t    region,
    output logic                oor_flag,
    output logic                ill_flag
);
    import crs_pkg::*;

    seq_state_t st_q, st_d;
    logic       boundary;

    assign boundary       = (st_q.step == '0);
    assign rd_addr.region = boundary ? new_region : st_q.region;
    assign rd_addr.step   = st_q.step;

    always_comb begin
        st_d = st_q;
        if (tick) begin
            if (boundary) begin
                st_d.region = new_region;
                if (new_oor) st_d.oor = 1'b1;
            end
            if (single_flip(rom_mode, st_q.mode)) st_d.mode = rom_mode;
            else                                  st_d.ill  = 1'b1;
            st_d.step = st_q.step + step_t'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign mode     = st_q.mode;
    assign region   = st_q.region;
    assign oor_flag = st_q.oor;
    assign ill_flag = st_q.ill;

    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q.mode));
    // R10
    single_flip_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(st_q.mode) |-> ($countones(st_q.mode ^ $past(st_q.mode)) == 1));
    // R4
    region_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !boundary) |=> $stable(st_q.region));
    // R7
    oor_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.oor |=> st_q.oor);
    // R8
    ill_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        st_q.ill |=> st_q.ill);
    // R8
    ill_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ($countones(rom_mode ^ st_q.mode) != 1)) |=> ($stable(st_q.mode) && st_q.ill));
endmodule

// File: rtl/cap_region_sequencer.sv
module cap_region_sequencer #(
    parameter int SMP_W    = 10,
    parameter int TICK_DIV = 4,
    parameter int V1_LO  = 145, parameter int V1_MID = 150, parameter int V1_HI = 155,
    parameter int V2_LO  = 95,  parameter int V2_MID = 100, parameter int V2_HI = 105,
    parameter int V3_LO  = 45,  parameter int V3_MID = 50,  parameter int V3_HI = 55
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SMP_W-1:0] v1_code,
    input  logic [SMP_W-1:0] v2_code,
    input  logic [SMP_W-1:0] v3_code,
    input  logic             sample_valid,
    input  logic             rom_wr_en,
    input  logic [2:0]       rom_wr_region,
    input  logic [2:0]       rom_wr_step,
    input  logic [3:0]       rom_wr_mode,
    output logic [3:0]       mode_o,
    output logic [2:0]       region_o,
    output logic             tick_o,
    output logic             out_of_range_o,
    output logic             illegal_transition_o
);
    import crs_pkg::*;

    logic      tick;
    region_t   cls_region;
    logic      cls_oor;
    rom_addr_t rd_addr;
    rom_addr_t wr_addr;
    mode_t     rd_mode;

    assign wr_addr.region = rom_wr_region;
    assign wr_addr.step   = rom_wr_step;

    crs_tick_div #(.DIV(TICK_DIV)) i_div (
        .clk(clk), .rst(rst), .tick(tick)
    );

    crs_region_classifier #(
        .VW(SMP_W),
        .V1_LO(V1_LO), .V1_MID(V1_MID), .V1_HI(V1_HI),
        .V2_LO(V2_LO), .V2_MID(V2_MID), .V2_HI(V2_HI),
        .V3_LO(V3_LO), .V3_MID(V3_MID), .V3_HI(V3_HI)
    ) i_cls (
        .clk(clk), .rst(rst), .sample_valid(sample_valid),
        .v1(v1_code), .v2(v2_code), .v3(v3_code),
        .region(cls_region), .outside_any(cls_oor)
    );

    crs_pattern_rom i_rom (
        .clk(clk), .rst(rst), .wr_en(rom_wr_en), .wr_addr(wr_addr),
        .wr_mode(rom_wr_mode), .rd_addr(rd_addr), .rd_mode(rd_mode)
    );

    crs_mode_stepper i_step (
        .clk(clk), .rst(rst), .tick(tick), .new_region(cls_region),
        .new_oor(cls_oor), .rom_mode(rd_mode), .rd_addr(rd_addr),
        .mode(mode_o), .region(region_o), .oor_flag(out_of_range_o),
        .ill_flag(illegal_transition_o)
    );

    assign tick_o = tick;
endmodule

// File: tb/test_cap_region_sequencer.sv
module test_cap_region_sequencer;
    localparam int DIV = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [9:0] v1_code = 10'd150, v2_code = 10'd100, v3_code = 10'd50;
    logic       sample_valid = 1'b1;
    logic       rom_wr_en = 1'b0;
    logic [2:0] rom_wr_region = '0, rom_wr_step = '0;
    logic [3:0] rom_wr_mode = '0;
    logic [3:0] mode_o;
    logic [2:0] region_o;
    logic       tick_o, out_of_range_o, illegal_transition_o;

    int checks = 0, errors = 0;
    int cyc = 0, last_tick = -1, ticks_seen = 0;
    int brom [8][8];
    int cur_mode = 0, exp_oor = 0, exp_ill = 0;

    cap_region_sequencer #(.TICK_DIV(DIV)) i_cap_region_sequencer (
        .clk(clk), .rst(rst), .v1_code(v1_code), .v2_code(v2_code), .v3_code(v3_code),
        .sample_valid(sample_valid), .rom_wr_en(rom_wr_en), .rom_wr_region(rom_wr_region),
        .rom_wr_step(rom_wr_step), .rom_wr_mode(rom_wr_mode), .mode_o(mode_o),
        .region_o(region_o), .tick_o(tick_o), .out_of_range_o(out_of_range_o),
        .illegal_transition_o(illegal_transition_o)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ref_mode(int r, int k);
        int b, m, rev;
        case (k)
            0: b = 4'b0001; 1: b = 4'b0011; 2: b = 4'b0111; 3: b = 4'b1111;
            4: b = 4'b1110; 5: b = 4'b1100; 6: b = 4'b1000; default: b = 4'b0000;
        endcase
        m = b;
        for (int s = 0; s < (r % 4); s++) m = ((m << 1) | (m >> 3)) & 15;
        if (r >= 4) begin
            rev = 0;
            for (int i = 0; i < 4; i++) if (m[i]) rev |= (1 << (3 - i));
            m = rev;
        end
        return m;
    endfunction

    task automatic drive(int a, int b, int c, bit vld);
        v1_code = 10'(a); v2_code = 10'(b); v3_code = 10'(c); sample_valid = vld;
    endtask

    task automatic wait_tick();
        while (tick_o !== 1'b1) @(negedge clk);
        check("R3", "mode before tick", int'(mode_o), cur_mode);
        if (ticks_seen > 0) check("R2", "tick gap", cyc - last_tick, DIV);
        last_tick = cyc;
        ticks_seen++;
        @(negedge clk);
        check("R2", "tick width", int'(tick_o), 0);
    endtask

    task automatic play(int r, bit mid, int m1, int m2, int m3);
        for (int k = 0; k < 8; k++) begin
            int prev = cur_mode;
            wait_tick();
            if ($countones(4'(brom[r][k] ^ cur_mode)) == 1) cur_mode = brom[r][k];
            else exp_ill = 1;
            check("R5", $sformatf("mode r%0d step%0d", r, k), int'(mode_o), cur_mode);
            check("R4", "region", int'(region_o), r);
            check("R7", "out_of_range", int'(out_of_range_o), exp_oor);
            check("R8", "illegal flag", int'(illegal_transition_o), exp_ill);
            if (int'(mode_o) != prev)
                check("R10", "bits changed", $countones(4'(int'(mode_o) ^ prev)), 1);
            if (mid && k == 3) drive(m1, m2, m3, 1'b1);
        end
    endtask

    task automatic rom_write(int r, int k, int m);
        rom_wr_en = 1'b1; rom_wr_region = 3'(r); rom_wr_step = 3'(k); rom_wr_mode = 4'(m);
        @(negedge clk);
        rom_wr_en = 1'b0;
        brom[r][k] = m;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1", "mode in reset", int'(mode_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "mode after release", int'(mode_o), 0);
        check("R1", "region after release", int'(region_o), 0);
        check("R1", "tick after release", int'(tick_o), 0);
        check("R1", "oor after release", int'(out_of_range_o), 0);
        check("R1", "ill after release", int'(illegal_transition_o), 0);
    endtask

    task automatic t_default_and_mid_sample();
        // R11: sample for region 2 captured mid-pattern, region 7 continues
        play(7, 1'b1, 148, 102, 47);
        // R6, R4: next pattern uses region 2
        play(2, 1'b0, 0, 0, 0);
    endtask

    task automatic t_box_edges();
        drive(145, 95, 45, 1'b1);
        play(0, 1'b0, 0, 0, 0);
        drive(155, 105, 55, 1'b1);
        play(7, 1'b0, 0, 0, 0);
    endtask

    task automatic t_out_of_range();
        // R7: v1 clamps to 155, v2 clamps to 95 -> region 5
        drive(170, 80, 50, 1'b1);
        exp_oor = 1;
        play(5, 1'b0, 0, 0, 0);
        drive(152, 96, 46, 1'b1);
        play(4, 1'b0, 0, 0, 0);
    endtask

    task automatic t_rom_write();
        int cust [8] = '{8, 9, 11, 10, 2, 6, 4, 0};
        // R9: load a custom legal pattern into region 3
        for (int k = 0; k < 8; k++) rom_write(3, k, cust[k]);
        drive(148, 102, 52, 1'b1);
        play(3, 1'b0, 0, 0, 0);
    endtask

    task automatic t_valid_gate_and_illegal();
        // R11: region-0 codes offered with sample_valid low are ignored
        drive(146, 96, 46, 1'b0);
        // R8: step 2 changes two bits from step 1
        rom_write(3, 2, 15);
        play(3, 1'b0, 0, 0, 0);
        check("R8", "illegal flag final", int'(illegal_transition_o), 1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 8; r++)
            for (int k = 0; k < 8; k++) brom[r][k] = ref_mode(r, k);
        @(negedge clk);
        t_reset();
        t_default_and_mid_sample();
        t_box_edges();
        t_out_of_range();
        t_rom_write();
        t_valid_gate_and_illegal();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule